// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the coherence controller of one cache in a small bus-based shared-memory system. It owns a direct-mapped cache of single-word lines, each tagged Invalid, Shared or Exclusive. Exclusive means this cache holds the only copy, the copy may be written, and memory is stale. The CPU side takes one read or write at a time through a ready/valid handshake. Each request is answered with a response pulse carrying a hit flag and a data word.

On a miss, the controller requests the shared bus and waits for an external grant. It then issues a read-miss, write-miss or write-back transaction and stalls the CPU until the transaction completes. It also watches every transaction that other caches place on the bus. A foreign read of a line it holds dirty makes it supply the word and demote the line to Shared. A foreign write miss makes it invalidate its copy, and it supplies the word first if the copy was dirty. The memory behind the bus is external.

Top module: `snc_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, and `bus_req`, `cpu_resp_valid` and `snp_flush` are 0. The line index is the low `IDX_W` address bits and the tag is the remaining high bits.
- R2: A CPU read of a valid line with a matching tag answers with hit=1 and the cached word, without a bus transaction. A read miss issues bus command 2'b01 (read miss), installs the fetched word as Shared and answers hit=0 with that word.
- R3: A CPU write that hits an Exclusive line updates the word and answers hit=1 without a bus transaction. A write miss issues bus command 2'b10 (write miss), installs the write data as Exclusive and answers hit=0.
- R4: A CPU write that hits a Shared line issues bus command 2'b10 to gain exclusivity, ignores the returned data, moves the line to Exclusive with the write data and answers hit=0.
- R5: A snooped read miss (2'b01) that matches an Exclusive line raises `snp_flush` with the word one cycle later and demotes the line to Shared. A snooped read of a Shared line raises no flush.
- R6: A snooped write miss (2'b10) that matches a valid line invalidates it, raising `snp_flush` with the word if the line was Exclusive. The next local read of that address misses and refetches over the bus.
- R7: A snoop whose tag differs from the stored tag at that index has no effect, and a snooped write-back (2'b11) has no effect.
- R8: A miss that displaces an Exclusive line first issues bus command 2'b11 (write-back) with the victim's address and word. A Shared victim is dropped without a write-back.
- R9: If a pending victim loses exclusivity to a snoop before its write-back is granted, the write-back is abandoned and only the miss transaction is issued.
- R10: A bus transaction completes only in a cycle with `bus_gnt` and `bus_ack` both high. Until then a miss keeps `bus_req` asserted, and the CPU sees `cpu_req_ready` low until its response has been delivered.
- R11: A snoop arriving in the same cycle as a CPU tag lookup takes priority. The lookup is repeated in the next cycle against the state the snoop left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_hit | output | 1 | Served without a bus transaction |
| cpu_resp_rdata | output | DATA_W | Read data (write data for writes) |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_ack | input | 1 | Memory completes the granted transaction |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data returned on completion |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies a dirty word |
| snp_fdata | output | DATA_W | Supplied word |

## Verification
Two collisions get targeted stimulus. In the first, a CPU read is accepted, and a snooped write miss to the same line is driven during the very cycle the controller performs its tag lookup. The response must then report a miss with freshly fetched data rather than a stale hit. In the second, the grant is withheld while the controller waits to write back a dirty victim, and a foreign read of that victim is snooped. The cache must supply the word at once, drop the write-back, and never issue the write-back once the grant returns.

// File: rtl/snc_pkg.sv
package snc_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'b00,
        BC_RDMISS = 2'b01,
        BC_WRMISS = 2'b10,
        BC_WRBACK = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_LOOK,
        C_WB,
        C_MISS
    } ctl_st_e;

    function automatic logic line_valid(line_st_e s);
        return s != ST_INV;
    endfunction

endpackage

// File: rtl/snc_line_store.sv
module snc_line_store
    import snc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              c_we,
    input  logic [IDX_W-1:0]  c_idx,
    input  line_st_e          c_st,
    input  logic [TAG_W-1:0]  c_tag,
    input  logic [DATA_W-1:0] c_data,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_st_e          s_st
);
    localparam int NLINES = 1 << IDX_W;

    line_st_e          st_q   [NLINES];
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [DATA_W-1:0] data_q [NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= ST_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (c_we && c_idx == IDX_W'(i)) begin
                st_q[i]   <= c_st;
                tag_q[i]  <= c_tag;
                data_q[i] <= c_data;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q[i]   <= s_st;
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(c_we && s_we)); // R11

endmodule

// File: rtl/snc_snoop.sv
module snc_snoop
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  look_idx,
    input  line_st_e          line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_we,
    output line_st_e          upd_st,
    output logic              flush_q,
    output logic [DATA_W-1:0] fdata_q
);
    logic match, dirty, supply;

    assign look_idx = snp_addr[IDX_W-1:0];
    assign match    = snp_valid && line_valid(line_st) &&
                      line_tag == snp_addr[ADDR_W-1:IDX_W];
    assign dirty    = line_st == ST_EXC;

    always_comb begin
        upd_we = 1'b0;
        upd_st = line_st;
        supply = 1'b0;
        if (match && snp_cmd == BC_RDMISS && dirty) begin
            upd_we = 1'b1;
            upd_st = ST_SHR;
            supply = 1'b1;
        end else if (match && snp_cmd == BC_WRMISS) begin
            upd_we = 1'b1;
            upd_st = ST_INV;
            supply = dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q <= 1'b0;
            fdata_q <= '0;
        end else begin
            flush_q <= supply;
            fdata_q <= supply ? line_data : '0;
        end
    end

    AST_WB_SNOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == BC_WRBACK) |=> !flush_q); // R7

endmodule

// File: rtl/snc_cpu_fsm.sv
module snc_cpu_fsm
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    input  logic              snp_valid,
    output logic [IDX_W-1:0]  look_idx,
    input  line_st_e          line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              c_we,
    output line_st_e          c_st,
    output logic [ADDR_W-IDX_W-1:0] c_tag,
    output logic [DATA_W-1:0] c_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    ctl_st_e          st_q;
    req_t             req_q;
    logic [TAG_W-1:0] req_tag;
    logic             hit_line, victim_dirty, done, look_go;

    assign look_idx     = req_q.addr[IDX_W-1:0];
    assign req_tag      = req_q.addr[ADDR_W-1:IDX_W];
    assign hit_line     = line_valid(line_st) && line_tag == req_tag;
    assign victim_dirty = line_st == ST_EXC && line_tag != req_tag;
    assign done         = bus_gnt && bus_ack;
    assign look_go      = st_q == C_LOOK && !snp_valid;
    assign req_ready    = st_q == C_IDLE;

    always_comb begin
        bus_req   = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = req_q.addr;
        bus_wdata = req_q.wdata;
        if (st_q == C_WB) begin
            bus_req   = victim_dirty;
            bus_cmd   = BC_WRBACK;
            bus_addr  = {line_tag, look_idx};
            bus_wdata = line_data;
        end else if (st_q == C_MISS) begin
            bus_req   = 1'b1;
            bus_cmd   = req_q.we ? BC_WRMISS : BC_RDMISS;
        end
    end

    always_comb begin
        c_we   = 1'b0;
        c_st   = ST_INV;
        c_tag  = req_tag;
        c_data = req_q.wdata;
        if (look_go && hit_line && req_q.we && line_st == ST_EXC) begin
            c_we = 1'b1;
            c_st = ST_EXC;
        end else if (st_q == C_WB && victim_dirty && done) begin
            c_we   = 1'b1;
            c_st   = ST_INV;
            c_tag  = line_tag;
            c_data = line_data;
        end else if (st_q == C_MISS && done) begin
            c_we   = 1'b1;
            c_st   = req_q.we ? ST_EXC : ST_SHR;
            c_data = req_q.we ? req_q.wdata : bus_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= C_IDLE;
            req_q      <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st_q)
                C_IDLE: if (req_valid) begin
                    req_q <= '{we: req_we, addr: req_addr, wdata: req_wdata};
                    st_q  <= C_LOOK;
                end
                C_LOOK: if (!snp_valid) begin
                    if (hit_line && (!req_q.we || line_st == ST_EXC)) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= req_q.we ? req_q.wdata : line_data;
                        st_q       <= C_IDLE;
                    end else if (!hit_line && victim_dirty) begin
                        st_q <= C_WB;
                    end else begin
                        st_q <= C_MISS;
                    end
                end
                C_WB: if (!victim_dirty || done) st_q <= C_MISS;
                C_MISS: if (done) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b0;
                    resp_data  <= req_q.we ? req_q.wdata : bus_rdata;
                    st_q       <= C_IDLE;
                end
                default: st_q <= C_IDLE;
            endcase
        end
    end

    AST_READ_HIT_QUICK: assert property (@(posedge clk) disable iff (rst)
        (look_go && hit_line && !req_q.we) |=> (resp_valid && resp_hit)); // R2
    AST_MISS_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (st_q == C_MISS && !done) |=> bus_req); // R10
    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> $past(!bus_req)); // R3

endmodule

// File: rtl/snc_cache_ctrl.sv
module snc_cache_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_fdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, b_idx;
    line_st_e          a_st, b_st, c_st, s_st;
    logic [TAG_W-1:0]  a_tag, b_tag, c_tag;
    logic [DATA_W-1:0] a_data, b_data, c_data;
    logic              c_we, s_we;
    bus_cmd_e          cmd_e;

    assign bus_cmd = cmd_e;

    snc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .c_we(c_we), .c_idx(a_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
        .s_we(s_we), .s_idx(b_idx), .s_st(s_st)
    );

    snc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_addr(snp_addr),
        .look_idx(b_idx), .line_st(b_st), .line_tag(b_tag), .line_data(b_data),
        .upd_we(s_we), .upd_st(s_st), .flush_q(snp_flush), .fdata_q(snp_fdata)
    );

    snc_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_we(cpu_req_we),
        .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
        .resp_valid(cpu_resp_valid), .resp_hit(cpu_resp_hit), .resp_data(cpu_resp_rdata),
        .snp_valid(snp_valid),
        .look_idx(a_idx), .line_st(a_st), .line_tag(a_tag), .line_data(a_data),
        .c_we(c_we), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_cmd(cmd_e),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    AST_FLUSH_CAUSED: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> $past(snp_valid)); // R5
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid); // R10
    AST_RESP_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> !$past(cpu_req_ready)); // R10

endmodule

// File: tb/snc_cache_ctrl_tb_top.sv
module snc_cache_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [15:0] cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
    logic [15:0] cpu_resp_rdata;
    logic        bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_flush;
    logic [15:0] snp_fdata;

    logic [15:0] mem [256];
    logic        gnt_en = 1'b1;
    logic [1:0]  last_cmd = '0;
    int          n_wb = 0, n_txn = 0;
    int          n_chk = 0, n_bad = 0;
    logic [16:0] q_val [$];
    string       q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    snc_cache_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_fdata(snp_fdata)
    );

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // memory model: grant and completion decided away from the clock edge
    always @(negedge clk) begin
        bus_gnt   <= bus_req && gnt_en;
        bus_ack   <= bus_req && gnt_en;
        bus_rdata <= mem[bus_addr];
    end

    always @(posedge clk) begin
        if (!rst && bus_req && bus_gnt && bus_ack) begin
            last_cmd = bus_cmd;
            n_txn++;
            if (bus_cmd == 2'b11) begin
                mem[bus_addr] = bus_wdata;
                n_wb++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cpu_resp_valid) begin
            if (q_val.size() == 0) begin
                chk("R10 unexpected response", 1, 0);
            end else begin
                logic [16:0] e;
                string t;
                e = q_val.pop_front();
                t = q_tag.pop_front();
                chk({t, " hit"}, 32'(cpu_resp_hit), 32'(e[16]));
                chk({t, " data"}, 32'(cpu_resp_rdata), 32'(e[15:0]));
            end
        end
    end

    task automatic cpu_op(bit we, logic [7:0] a, logic [15:0] wd,
                          bit eh, logic [15:0] ed, string r);
        q_val.push_back({eh, ed});
        q_tag.push_back(r);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        wait (q_val.size() == 0);
        @(negedge clk);
    endtask

    task automatic snoop(logic [1:0] c, logic [7:0] a, bit ef, logic [15:0] ed, string r);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        @(negedge clk);
        snp_valid = 1'b0;
        chk({r, " flush"}, 32'(snp_flush), 32'(ef));
        if (ef) chk({r, " flush data"}, 32'(snp_fdata), 32'(ed));
        if (snp_flush) mem[a] = snp_fdata;
    endtask

    bit finished = 1'b0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int txn0, wb0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", 32'(cpu_req_ready), 1);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 resp", 32'(cpu_resp_valid), 0);
        chk("R1 flush", 32'(snp_flush), 0);

        cpu_op(0, 8'h04, 0, 0, 16'h1004, "R1 R2 cold read miss");
        chk("R2 read-miss cmd", 32'(last_cmd), 2'b01);
        cpu_op(0, 8'h04, 0, 1, 16'h1004, "R2 read hit");

        txn0 = n_txn;
        cpu_op(1, 8'h04, 16'hAAAA, 0, 16'hAAAA, "R4 upgrade");
        chk("R4 upgrade cmd", 32'(last_cmd), 2'b10);
        chk("R4 one txn", 32'(n_txn - txn0), 1);
        cpu_op(0, 8'h04, 0, 1, 16'hAAAA, "R3 read after upgrade");
        txn0 = n_txn;
        cpu_op(1, 8'h04, 16'hA5A5, 1, 16'hA5A5, "R3 write hit exclusive");
        chk("R3 no bus txn", 32'(n_txn - txn0), 0);

        snoop(2'b01, 8'h04, 1, 16'hA5A5, "R5 snoop read dirty");
        cpu_op(1, 8'h04, 16'hBBBB, 0, 16'hBBBB, "R5 demoted to shared");
        snoop(2'b10, 8'h04, 1, 16'hBBBB, "R6 snoop write dirty");
        cpu_op(0, 8'h04, 0, 0, 16'hBBBB, "R6 refetch after invalidate");
        chk("R6 refetch cmd", 32'(last_cmd), 2'b01);
        snoop(2'b01, 8'h04, 0, 0, "R5 snoop read shared");

        cpu_op(1, 8'h08, 16'h5555, 0, 16'h5555, "R3 write miss");
        chk("R3 write-miss cmd", 32'(last_cmd), 2'b10);
        wb0 = n_wb;
        cpu_op(0, 8'h0C, 0, 0, 16'h100C, "R8 evict dirty");
        chk("R8 one write-back", 32'(n_wb - wb0), 1);
        chk("R8 victim in memory", 32'(mem[8'h08]), 32'h5555);
        cpu_op(0, 8'h10, 0, 0, 16'h1010, "R8 evict shared");
        chk("R8 no write-back", 32'(n_wb - wb0), 1);

        snoop(2'b10, 8'h14, 0, 0, "R7 other tag");
        cpu_op(0, 8'h10, 0, 1, 16'h1010, "R7 line kept after other-tag snoop");
        snoop(2'b11, 8'h10, 0, 0, "R7 snooped write-back");
        cpu_op(0, 8'h10, 0, 1, 16'h1010, "R7 line kept after write-back snoop");

        // R11: snoop collides with the lookup cycle
        q_val.push_back({1'b0, 16'h1010});
        q_tag.push_back("R11 snoop beats lookup");
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = 8'h10;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        snp_valid = 1'b1;
        snp_cmd   = 2'b10;
        snp_addr  = 8'h10;
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R11 shared line no flush", 32'(snp_flush), 0);
        wait (q_val.size() == 0);
        @(negedge clk);

        cpu_op(1, 8'h20, 16'h7777, 0, 16'h7777, "R3 write miss into idx0");

        // R9: victim loses exclusivity while write-back waits for grant
        wb0 = n_wb;
        gnt_en = 1'b0;
        fork
            cpu_op(0, 8'h24, 0, 0, 16'h1024, "R9 miss after dropped write-back");
            begin
                @(negedge clk);
                while (!(bus_req && bus_cmd == 2'b11)) @(negedge clk);
                chk("R10 stalled ready", 32'(cpu_req_ready), 0);
                chk("R8 write-back address", 32'(bus_addr), 32'h20);
                snoop(2'b01, 8'h20, 1, 16'h7777, "R9 supply pending victim");
                repeat (2) @(negedge clk);
                chk("R10 held without grant", 32'(bus_req), 1);
                chk("R9 no write-back pending", 32'(bus_cmd), 2'b01);
                gnt_en = 1'b1;
            end
        join
        chk("R9 write-back dropped", 32'(n_wb - wb0), 0);
        chk("R9 last cmd read miss", 32'(last_cmd), 2'b01);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule